// File: doc/BRIEF.md
# Read-Modify-Write Bus Cycle Sequencer

This block sequences the external bus for a single-operand memory-modify instruction. In its long form the instruction carries a two-byte absolute address that is indexed by an internal index register. The sequencer fetches the opcode and both address bytes, then always spends one cycle reading at the address with no carry applied. It reads the operand at the corrected address, writes the unmodified operand back, and finally writes the modified value. In its short form it operates on an internal accumulator in two cycles.

The modification itself is outside the block. The sequencer presents the operand and the current carry flag, and takes back a result byte and a carry-out. It keeps the program counter, the index register, the accumulator and the carry, negative and zero flags. A load strobe, accepted only while idle, presets the program counter, index, accumulator and carry. A start pulse with a mode bit begins an instruction. A ready input stretches any read cycle but has no effect on write cycles.

Top module: `rmw_seq`

## Requirements
- R1: After reset, busy, wr, dout, acc and all three flags are 0, and addr is 0.
- R2: With mode_acc = 0, a start accepted while idle gives seven busy cycles. Cycles 1 to 3 drive addresses P, P+1 and P+2, where P is the program counter at start. The byte read in cycle 2 is the address low byte L, and the byte read in cycle 3 is the high byte H. Cycles 5 to 7 all drive the effective address.
- R3: Cycle 4 reads at {H, (L+X) mod 256}, whether or not L+X overflows. The effective address is {H + carry of L+X, (L+X) mod 256}.
- R4: wr is 1 only in cycles 6 and 7. In cycle 6, dout equals the byte read in cycle 5. In cycle 7, dout equals mod_res as it was for that operand.
- R5: mod_arg carries the operand byte, and mod_cin carries the current carry flag.
- R6: At the end of cycle 7 the flags take C = mod_cout, N = result bit 7 and Z = (result == 0). The program counter becomes P+3, and the next cycle drives P+3.
- R7: rdy = 0 during a read cycle (any busy cycle except 6 and 7) repeats that cycle with the same address. rdy is ignored in cycles 6 and 7.
- R8: With mode_acc = 1, the instruction is busy for 2 cycles. It drives P in cycle 1 and P+1 in cycle 2, and the program counter stays at P+1 with wr held at 0. acc and the flags take the result at the end of the cycle that follows cycle 2.
- R9: A start that arrives during a busy cycle other than the last one is ignored. A start during the last cycle begins the next instruction in the following cycle, at the updated program counter.
- R10: load is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction |
| mode_acc | input | 1 | 1 = accumulator form, 0 = absolute indexed form |
| rdy | input | 1 | Ready; 0 stretches a read cycle |
| load | input | 1 | Preset registers (idle only) |
| load_pc | input | 16 | Program counter preset |
| load_x | input | 8 | Index preset |
| load_acc | input | 8 | Accumulator preset |
| load_c | input | 1 | Carry flag preset |
| addr | output | 16 | Address bus |
| din | input | 8 | Read data |
| dout | output | 8 | Write data |
| wr | output | 1 | Write strobe |
| busy | output | 1 | Instruction in progress |
| mod_arg | output | 8 | Operand to the modify function |
| mod_cin | output | 1 | Carry into the modify function |
| mod_res | input | 8 | Modified value |
| mod_cout | input | 1 | Carry out of the modify function |
| acc | output | 8 | Accumulator |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench runs the indexed form with and without a low-byte overflow. A design that skips the dummy read, or applies the carry early, would put the wrong address on the bus in cycle 4. A design that forgets the carry would write to a page one below the target. Holding ready low during the dummy read must repeat that cycle, while holding it low across both writes must change nothing. A design that gates writes with ready would stall there. Further runs chain an accumulator instruction directly behind a memory one and check that the accumulator changes one cycle late. They also pulse start and load mid-instruction, which a sloppy sequencer would act on.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADL,
        ST_ADH,
        ST_FALSE,
        ST_DATA,
        ST_WR1,
        ST_WR2,
        ST_ACC
    } seq_state_e;

    typedef enum logic {
        MODE_ABSX = 1'b0,
        MODE_ACC  = 1'b1
    } seq_mode_e;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
    } flags_t;

    // cycles in which the bus reads and a low ready stalls the sequence
    function automatic logic is_read_state(seq_state_e s);
        case (s)
            ST_OPC, ST_ADL, ST_ADH, ST_FALSE, ST_DATA, ST_ACC: return 1'b1;
            default:                                           return 1'b0;
        endcase
    endfunction

    function automatic logic is_last_state(seq_state_e s);
        return (s == ST_WR2) || (s == ST_ACC);
    endfunction

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode_acc,
    input  logic       rdy,
    output seq_state_e state,
    output logic       advance,
    output logic       busy
);
    seq_state_e state_q, state_d;
    seq_mode_e  mode_q;
    logic       take;

    assign advance = is_read_state(state_q) ? rdy : 1'b1;
    assign take    = start && ((state_q == ST_IDLE) || (is_last_state(state_q) && advance));

    always_comb begin
        state_d = state_q;
        if (advance) begin
            case (state_q)
                ST_IDLE:  state_d = take ? ST_OPC : ST_IDLE;
                ST_OPC:   state_d = (mode_q == MODE_ACC) ? ST_ACC : ST_ADL;
                ST_ADL:   state_d = ST_ADH;
                ST_ADH:   state_d = ST_FALSE;
                ST_FALSE: state_d = ST_DATA;
                ST_DATA:  state_d = ST_WR1;
                ST_WR1:   state_d = ST_WR2;
                ST_WR2:   state_d = take ? ST_OPC : ST_IDLE;
                ST_ACC:   state_d = take ? ST_OPC : ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_ABSX;
        end else begin
            state_q <= state_d;
            if (take) mode_q <= mode_acc ? MODE_ACC : MODE_ABSX;
        end
    end

    assign state = state_q;
    assign busy  = (state_q != ST_IDLE);

    // R7: write cycles advance whatever ready does
    p_write_no_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR1) |=> (state_q == ST_WR2));

    // R9: a start mid-instruction does not restart the sequence
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADL && rdy) |=> (state_q == ST_ADH));

    // R2: an accepted start from idle makes the block busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start) |=> busy);
endmodule

// File: rtl/rmw_addr.sv
module rmw_addr
    import rmw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_e    state,
    input  logic          advance,
    input  logic          load,
    input  logic [AW-1:0] load_pc,
    input  logic [DW-1:0] load_x,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr
);
    localparam int HW = AW - DW;

    logic [AW-1:0] pc_q;
    logic [DW-1:0] x_q, adl_q, lo_q;
    logic [HW-1:0] adh_q, eahi_q;
    logic          cy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            x_q    <= '0;
            adl_q  <= '0;
            lo_q   <= '0;
            adh_q  <= '0;
            eahi_q <= '0;
            cy_q   <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (load) begin
                pc_q <= load_pc;
                x_q  <= load_x;
            end
        end else if (advance) begin
            case (state)
                ST_OPC: pc_q <= pc_q + 1'b1;
                ST_ADL: begin
                    adl_q <= din;
                    pc_q  <= pc_q + 1'b1;
                end
                ST_ADH: begin
                    adh_q         <= din[HW-1:0];
                    {cy_q, lo_q}  <= {1'b0, adl_q} + {1'b0, x_q};
                    pc_q          <= pc_q + 1'b1;
                end
                ST_FALSE: eahi_q <= adh_q + {{(HW-1){1'b0}}, cy_q};
                default: ;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_FALSE:               addr = {adh_q, lo_q};
            ST_DATA, ST_WR1, ST_WR2: addr = {eahi_q, lo_q};
            default:                addr = pc_q;
        endcase
    end

    // R3: the low byte is unchanged from the dummy read to the operand read
    p_low_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FALSE && advance) |=> (addr[DW-1:0] == $past(addr[DW-1:0])));

    // R2: the effective address is held through both writes
    p_ea_held_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR1 || state == ST_WR2) |-> (addr == $past(addr)));

    // R8: the short form holds the program counter in its second cycle
    p_pc_held_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACC) |=> (pc_q == $past(pc_q)));
endmodule

// File: rtl/rmw_data.sv
module rmw_data
    import rmw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_e    state,
    input  logic          advance,
    input  logic          load,
    input  logic [DW-1:0] load_acc,
    input  logic          load_c,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] mod_res,
    input  logic          mod_cout,
    output logic [DW-1:0] mod_arg,
    output logic          mod_cin,
    output logic [DW-1:0] dout,
    output logic          wr,
    output logic [DW-1:0] acc,
    output flags_t        flags
);
    logic [DW-1:0] opnd_q, res_q, acc_q;
    logic          rc_q, pend_q;
    flags_t        flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q  <= '0;
            res_q   <= '0;
            acc_q   <= '0;
            rc_q    <= 1'b0;
            pend_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            if (pend_q) begin
                acc_q   <= res_q;
                flags_q <= '{c: rc_q, n: res_q[DW-1], z: (res_q == '0)};
                pend_q  <= 1'b0;
            end else if (load && state == ST_IDLE) begin
                acc_q     <= load_acc;
                flags_q.c <= load_c;
            end
            if (state == ST_DATA && advance) opnd_q <= din;
            if (state == ST_WR1 || (state == ST_ACC && advance)) begin
                res_q <= mod_res;
                rc_q  <= mod_cout;
            end
            if (state == ST_ACC && advance) pend_q <= 1'b1;
            if (state == ST_WR2)
                flags_q <= '{c: rc_q, n: res_q[DW-1], z: (res_q == '0)};
        end
    end

    assign mod_arg = (state == ST_ACC) ? acc_q : opnd_q;
    assign mod_cin = flags_q.c;
    assign wr      = (state == ST_WR1) || (state == ST_WR2);
    always_comb begin
        case (state)
            ST_WR1:  dout = opnd_q;
            ST_WR2:  dout = res_q;
            default: dout = '0;
        endcase
    end
    assign acc   = acc_q;
    assign flags = flags_q;

    // R4: the first write echoes the byte read in the previous cycle
    p_first_write_echo_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR1) |-> (dout == $past(din)));

    // R6: zero and negative follow the byte stored by the final write
    p_flags_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR2) |=> (flags_q.z == ($past(dout) == '0) && flags_q.n == $past(dout[DW-1])));

    // R8: the accumulator takes the result two edges after the short form's second cycle
    p_acc_late_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACC && advance) |-> ##2 (acc_q == $past(mod_res, 2)));
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode_acc,
    input  logic          rdy,
    input  logic          load,
    input  logic [AW-1:0] load_pc,
    input  logic [DW-1:0] load_x,
    input  logic [DW-1:0] load_acc,
    input  logic          load_c,
    output logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          wr,
    output logic          busy,
    output logic [DW-1:0] mod_arg,
    output logic          mod_cin,
    input  logic [DW-1:0] mod_res,
    input  logic          mod_cout,
    output logic [DW-1:0] acc,
    output logic          flag_c,
    output logic          flag_n,
    output logic          flag_z
);
    seq_state_e state;
    logic       advance;
    flags_t     flags;

    rmw_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_acc (mode_acc),
        .rdy      (rdy),
        .state    (state),
        .advance  (advance),
        .busy     (busy)
    );

    rmw_addr #(.AW(AW), .DW(DW)) i_addr (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .advance (advance),
        .load    (load),
        .load_pc (load_pc),
        .load_x  (load_x),
        .din     (din),
        .addr    (addr)
    );

    rmw_data #(.DW(DW)) i_data (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .advance  (advance),
        .load     (load),
        .load_acc (load_acc),
        .load_c   (load_c),
        .din      (din),
        .mod_res  (mod_res),
        .mod_cout (mod_cout),
        .mod_arg  (mod_arg),
        .mod_cin  (mod_cin),
        .dout     (dout),
        .wr       (wr),
        .acc      (acc),
        .flags    (flags)
    );

    assign flag_c = flags.c;
    assign flag_n = flags.n;
    assign flag_z = flags.z;

    // R4: writes only happen inside an instruction
    p_wr_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
        wr |-> busy);
endmodule

// File: tb/test_rmw_seq.sv
module test_rmw_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, mode_acc = 1'b0, rdy = 1'b1, load = 1'b0, load_c = 1'b0;
    logic [15:0] load_pc = '0;
    logic [7:0]  load_x = '0, load_acc = '0;
    logic [15:0] addr;
    logic [7:0]  din, dout, mod_arg, mod_res, acc;
    logic        wr, busy, mod_cin, mod_cout, flag_c, flag_n, flag_z;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return (a[7:0] ^ 8'hA5) + a[15:8];
    endfunction

    assign din      = memf(addr);
    assign mod_res  = {mod_arg[6:0], mod_cin};
    assign mod_cout = mod_arg[7];

    rmw_seq i_rmw_seq (
        .clk(clk), .rst(rst), .start(start), .mode_acc(mode_acc), .rdy(rdy),
        .load(load), .load_pc(load_pc), .load_x(load_x), .load_acc(load_acc),
        .load_c(load_c), .addr(addr), .din(din), .dout(dout), .wr(wr), .busy(busy),
        .mod_arg(mod_arg), .mod_cin(mod_cin), .mod_res(mod_res), .mod_cout(mod_cout),
        .acc(acc), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic preset(input logic [15:0] pc0, input logic [7:0] x0,
                          input logic [7:0] a0, input logic c0);
        load = 1'b1; load_pc = pc0; load_x = x0; load_acc = a0; load_c = c0;
        step();
        load = 1'b0;
    endtask

    // memory form; stall: ready low in the dummy read and both writes;
    // ign: start and load pulsed mid-instruction; chain: short form follows at once
    task automatic run_abs(input logic [15:0] pc0, input bit want_cy, input logic c0,
                           input bit stall, input bit ign, input bit chain,
                           input logic [7:0] a0);
        logic [7:0]  adl, adh, x0, op, res, res2;
        logic [8:0]  sum;
        logic [15:0] fa, ea;
        adl = memf(pc0 + 16'd1);
        adh = memf(pc0 + 16'd2);
        x0  = want_cy ? (8'd3 - adl) : (8'hFE - adl);
        sum = {1'b0, adl} + {1'b0, x0};
        fa  = {adh, sum[7:0]};
        ea  = {adh + {7'd0, sum[8]}, sum[7:0]};
        preset(pc0, x0, a0, c0);
        start = 1'b1; mode_acc = 1'b0;
        step();
        start = 1'b0;
        chk("R2", "c1 addr", {16'd0, addr}, {16'd0, pc0});
        chk("R2", "c1 busy", {31'd0, busy}, 32'd1);
        step();
        chk("R2", "c2 addr", {16'd0, addr}, {16'd0, pc0 + 16'd1});
        step();
        chk("R2", "c3 addr", {16'd0, addr}, {16'd0, pc0 + 16'd2});
        if (ign) begin
            start = 1'b1; load = 1'b1; load_pc = 16'h1234; load_acc = 8'h77;
        end
        step();
        start = 1'b0; load = 1'b0;
        chk("R3", "c4 dummy read addr", {16'd0, addr}, {16'd0, fa});
        chk("R4", "c4 wr", {31'd0, wr}, 32'd0);
        if (stall) begin
            rdy = 1'b0;
            step();
            chk("R7", "stall 1 addr", {16'd0, addr}, {16'd0, fa});
            step();
            chk("R7", "stall 2 addr", {16'd0, addr}, {16'd0, fa});
            rdy = 1'b1;
        end
        step();
        chk("R3", "c5 effective addr", {16'd0, addr}, {16'd0, ea});
        op  = memf(ea);
        res = {op[6:0], c0};
        step();
        if (stall) rdy = 1'b0;
        chk("R4", "c6 wr", {31'd0, wr}, 32'd1);
        chk("R4", "c6 dout", {24'd0, dout}, {24'd0, op});
        chk("R2", "c6 addr", {16'd0, addr}, {16'd0, ea});
        chk("R5", "c6 mod_arg", {24'd0, mod_arg}, {24'd0, op});
        chk("R5", "c6 mod_cin", {31'd0, mod_cin}, {31'd0, c0});
        step();
        chk("R7", "c7 reached under low ready", {31'd0, wr}, 32'd1);
        chk("R4", "c7 dout", {24'd0, dout}, {24'd0, res});
        chk("R2", "c7 addr", {16'd0, addr}, {16'd0, ea});
        if (chain) begin
            start = 1'b1; mode_acc = 1'b1;
        end
        step();
        start = 1'b0; rdy = 1'b1;
        chk("R6", "flag C", {31'd0, flag_c}, {31'd0, op[7]});
        chk("R6", "flag N", {31'd0, flag_n}, {31'd0, res[7]});
        chk("R6", "flag Z", {31'd0, flag_z}, {31'd0, (res == 8'd0)});
        chk("R6", "next fetch addr", {16'd0, addr}, {16'd0, pc0 + 16'd3});
        if (chain) begin
            chk("R9", "chained start busy", {31'd0, busy}, 32'd1);
            step();
            chk("R8", "chained c2 addr", {16'd0, addr}, {16'd0, pc0 + 16'd4});
            res2 = {a0[6:0], op[7]};
            step();
            chk("R8", "chained acc not yet written", {24'd0, acc}, {24'd0, a0});
            step();
            chk("R8", "chained acc", {24'd0, acc}, {24'd0, res2});
            chk("R8", "chained C", {31'd0, flag_c}, {31'd0, a0[7]});
        end else begin
            chk("R2", "idle after c7", {31'd0, busy}, 32'd0);
            if (ign) begin
                step();
                chk("R9", "mid start not queued", {31'd0, busy}, 32'd0);
                chk("R10", "mid load pc ignored", {16'd0, addr}, {16'd0, pc0 + 16'd3});
                chk("R10", "mid load acc ignored", {24'd0, acc}, {24'd0, a0});
            end
        end
    endtask

    task automatic run_acc(input logic [15:0] pc0, input logic [7:0] a0, input logic c0);
        logic [7:0] res;
        res = {a0[6:0], c0};
        preset(pc0, 8'h00, a0, c0);
        start = 1'b1; mode_acc = 1'b1;
        step();
        start = 1'b0;
        chk("R8", "acc c1 addr", {16'd0, addr}, {16'd0, pc0});
        chk("R8", "acc c1 busy", {31'd0, busy}, 32'd1);
        step();
        chk("R8", "acc c2 addr", {16'd0, addr}, {16'd0, pc0 + 16'd1});
        chk("R8", "acc c2 wr", {31'd0, wr}, 32'd0);
        chk("R5", "acc mod_arg", {24'd0, mod_arg}, {24'd0, a0});
        step();
        chk("R8", "acc done busy", {31'd0, busy}, 32'd0);
        chk("R8", "acc pc held", {16'd0, addr}, {16'd0, pc0 + 16'd1});
        chk("R8", "acc before write", {24'd0, acc}, {24'd0, a0});
        step();
        chk("R8", "acc result", {24'd0, acc}, {24'd0, res});
        chk("R8", "acc C", {31'd0, flag_c}, {31'd0, a0[7]});
        chk("R8", "acc Z", {31'd0, flag_z}, {31'd0, (res == 8'd0)});
        chk("R8", "acc N", {31'd0, flag_n}, {31'd0, res[7]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "wr", {31'd0, wr}, 32'd0);
        chk("R1", "acc", {24'd0, acc}, 32'd0);
        chk("R1", "flags", {29'd0, flag_c, flag_n, flag_z}, 32'd0);
        chk("R1", "addr", {16'd0, addr}, 32'd0);
        chk("R1", "dout", {24'd0, dout}, 32'd0);
        step();
        run_abs(16'h0200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // carry into high byte
        run_abs(16'h4F10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00); // no carry, carry-in 1
        run_abs(16'h3300, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00); // R7 ready stalls
        run_abs(16'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C); // R9, R10 ignored inputs
        run_abs(16'h2220, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC1); // R9 chained short form
        run_acc(16'h0800, 8'h81, 1'b0);
        run_acc(16'h0900, 8'h80, 1'b0); // zero result
        run_acc(16'h0A00, 8'h40, 1'b1); // negative result
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule